// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a descriptor-driven network DMA. It takes an incoming frame as a byte stream, computes a CRC-32 over the payload and appends the four CRC bytes. It spreads the result across the data buffers of a ring of 8-byte descriptors held in memory. Each filled buffer has its descriptor rewritten with the stored byte count and updated status bits, and the block pulses a buffer event or a frame event for it.

Software builds the ring with the empty bit set in every descriptor and sets the enable input. While disabled, the engine parks its descriptor pointer at the ring start. A demand strobe makes the engine inspect the current descriptor. After that, the receive-ready state follows the empty bit of whichever descriptor comes next. Incoming bytes are back-pressured while the engine is not ready. Address filtering and MAC-level parsing are done elsewhere.

Memory is reached over a simple word port with one cycle of read latency. The layout is big-endian: the byte at an address ending in 0 sits on bits 31:24.

Top module: `rx_ring_engine`

## Requirements
- R1: The bytes stored for a frame are the payload followed by its CRC-32. The CRC is reflected, polynomial 0xEDB88320, seeded with all ones and inverted at the end, and is stored most significant byte first. The length recorded for the frame totals the payload count plus 4. Byte writes enable exactly one lane: `mem_be_o[3]` carries address offset 0 on bits 31:24, down to `mem_be_o[0]` for offset 3.
- R2: When payload plus 4 exceeds MAX_FRAME (2032), only the first MAX_FRAME-4 payload bytes are stored, followed by the CRC, so the lengths total 2032. The last descriptor then has flag bit 0 (truncated) and flag bit 5 (length error) set.
- R3: Flag bit 5 is also set in the last descriptor when the stored total exceeds `max_len_i`. This input is the upper half of the receive-control setting, whose reset value is 0x05EE.
- R4: The buffer size is `max_buf_i` with only bits 10:4 kept; a result of zero counts as 16. Each buffer receives the smaller of the remaining bytes and the buffer size, so every non-final buffer is completely full.
- R5: A descriptor is the word at its address, followed by the buffer pointer at address+4. The word holds flags in bits 31:16 and length in bits 15:0. The flag bits are: 15 empty, 13 wrap, 11 last. Write-back clears the empty bit and keeps the other flags. The final buffer also gets the last bit and the error bits and pulses `evt_rxf_o`; every other buffer pulses `evt_rxb_o`.
- R6: After a descriptor is used, the next one is at the ring start if its wrap bit is set, and at address+8 otherwise.
- R7: If a descriptor without the empty bit is met in the middle of a frame, the rest of the frame is consumed and discarded. That descriptor is not written and no frame event is raised.
- R8: After each frame, and on a demand strobe while enabled and not ready, `ready_o` takes the empty bit of the current descriptor. `rdar_o` shows it at bit 24, with all other bits zero.
- R9: With `enable_i` low, `ready_o` is low from the next cycle and the descriptor pointer returns to the ring start.
- R10: `rx_ready_o` is low whenever `ready_o` is low, so no bytes are taken while the engine is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Receive enable |
| demand_i | input | 1 | Receive-demand strobe |
| ring_base_i | input | ADDR_W | Ring start address |
| max_buf_i | input | BUFSZ_W | Maximum buffer size (bits 10:4 used) |
| max_len_i | input | LEN_W | Maximum frame length |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Final payload byte of the frame |
| rx_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_rd_o | output | 1 | Memory word read, data on the next cycle |
| mem_wr_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | 4 | Write byte lanes, bit 3 = bits 31:24 |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| ready_o | output | 1 | Receive-ready state |
| rdar_o | output | 32 | Demand register read value |
| evt_rxb_o | output | 1 | Buffer-filled event pulse |
| evt_rxf_o | output | 1 | Frame-complete event pulse |

## Verification
The bound checker watches every descriptor write-back on every cycle. It checks that the empty bit is cleared, that the last bit matches the kind of event raised, that non-final buffers are full and no buffer exceeds the buffer size, and that truncation always comes with the length error. It also checks that byte writes use one lane, that disabling drops readiness, and that the stream is never accepted while not ready. Some behaviours only the bench scenarios can show: CRC values and byte placement, wrap back to the ring start, the drop path at a busy descriptor, and readiness derived from descriptor contents. The same holds for the pointer reset on disable, the masking of the buffer size, and the 2032-byte truncation.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH1,
        ST_FETCH2,
        ST_DATA,
        ST_CLOSE,
        ST_DROP,
        ST_PROBE0,
        ST_PROBE1
    } rxr_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } desc_word_t;

    localparam int FLG_EMPTY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int FLG_LONG  = 5;
    localparam int FLG_TRUNC = 0;

    localparam int DESC_BYTES = 8;
    localparam int CRC_BYTES  = 4;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // One byte of reflected CRC-32, bit by bit from the data LSB.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = {1'b0, r[31:1]} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

    // Big-endian lane select: offset 0 lives on bits 31:24.
    function automatic logic [3:0] lane_be(input logic [1:0] lane);
        return 4'b1000 >> lane;
    endfunction

endpackage

// File: rtl/rxr_crc32.sv
module rxr_crc32
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear_i,
    input  logic        en_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            crc_q <= '1;
        end else if (en_i) begin
            crc_q <= crc_step(crc_q, data_i);
        end
    end

    assign crc_o = ~crc_q;

endmodule

// File: rtl/rxr_frame_len.sv
module rxr_frame_len #(
    parameter int MAX_FRAME = 2032,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             inc_i,
    input  logic [LEN_W-1:0] max_len_i,
    output logic             store_ok_o,
    output logic             trunc_o,
    output logic             long_o
);

    localparam logic [LEN_W-1:0] PAY_SAT   = LEN_W'((1 << LEN_W) - 5);
    localparam logic [LEN_W-1:0] STORE_LIM = LEN_W'(MAX_FRAME - 4);
    localparam logic [LEN_W-1:0] FRAME_LIM = LEN_W'(MAX_FRAME);

    logic [LEN_W-1:0] pay_q;
    logic [LEN_W-1:0] total;
    logic [LEN_W-1:0] stored;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pay_q <= '0;
        end else if (inc_i && pay_q != PAY_SAT) begin
            pay_q <= pay_q + 1'b1;
        end
    end

    always_comb begin
        total      = pay_q + LEN_W'(4);
        trunc_o    = total > FRAME_LIM;
        stored     = trunc_o ? FRAME_LIM : total;
        long_o     = trunc_o || (stored > max_len_i);
        store_ok_o = pay_q < STORE_LIM;
    end

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              advance_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] cur_o
);

    logic [ADDR_W-1:0] base_al;
    logic              unused_base;

    assign base_al     = {base_i[ADDR_W-1:2], 2'b00};
    assign unused_base = ^base_i[1:0];

    always_ff @(posedge clk) begin
        if (rst || !enable_i) begin
            cur_o <= base_al;
        end else if (advance_i) begin
            cur_o <= wrap_i ? base_al : cur_o + ADDR_W'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUFSZ_W   = 11,
    parameter int MAX_FRAME = 2032,
    parameter int LEN_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_i,
    input  logic               demand_i,
    input  logic [ADDR_W-1:0]  ring_base_i,
    input  logic [BUFSZ_W-1:0] max_buf_i,
    input  logic [LEN_W-1:0]   max_len_i,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_data_i,
    input  logic               rx_last_i,
    output logic               rx_ready_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [3:0]         mem_be_o,
    output logic [31:0]        mem_wdata_o,
    input  logic [31:0]        mem_rdata_i,
    output logic               ready_o,
    output logic [31:0]        rdar_o,
    output logic               evt_rxb_o,
    output logic               evt_rxf_o
);

    localparam int CNT_W = BUFSZ_W + 1;
    localparam logic [BUFSZ_W-1:0] BUF_FLOOR = BUFSZ_W'(16);

    rxr_state_e         state_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ADDR_W-1:0]  bufptr_q;
    logic [BUFSZ_W-1:0] bufcnt_q;
    logic [15:0]        flags_q;
    logic               pay_done_q;
    logic               last_q;
    logic [1:0]         crc_idx_q;
    logic               ready_q;

    logic [BUFSZ_W-1:0] masked_max;
    logic [BUFSZ_W-1:0] eff_max;
    logic               unused_low;
    logic [31:0]        crc_fin;
    logic               store_ok;
    logic               trunc_flag;
    logic               long_flag;
    logic               frame_start;
    logic               byte_take;
    logic               crc_turn;
    logic               wr_byte;
    logic               buf_full;
    logic               crc_end;
    logic [7:0]         crc_byte;
    logic [7:0]         wbyte;
    logic [ADDR_W-1:0]  byte_addr;
    logic [15:0]        flags_new;
    desc_word_t         wb_word;

    // Buffer size: bits above 3 only, zero promoted to one granule.
    assign masked_max = {max_buf_i[BUFSZ_W-1:4], 4'b0000};
    assign eff_max    = (masked_max == '0) ? BUF_FLOOR : masked_max;
    assign unused_low = ^max_buf_i[3:0];

    assign frame_start = (state_q == ST_IDLE) && enable_i && ready_q && rx_valid_i;
    assign byte_take   = (state_q == ST_DATA) && !pay_done_q && rx_valid_i;
    assign crc_turn    = (state_q == ST_DATA) && pay_done_q;
    assign wr_byte     = (byte_take && store_ok) || crc_turn;
    assign buf_full    = (CNT_W'(bufcnt_q) + 1'b1) == CNT_W'(eff_max);
    assign crc_end     = crc_turn && (crc_idx_q == 2'd3);
    assign byte_addr   = bufptr_q + ADDR_W'(bufcnt_q);

    rxr_crc32 u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (frame_start),
        .en_i    (byte_take),
        .data_i  (rx_data_i),
        .crc_o   (crc_fin)
    );

    rxr_frame_len #(
        .MAX_FRAME (MAX_FRAME),
        .LEN_W     (LEN_W)
    ) u_len (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (frame_start),
        .inc_i      (byte_take),
        .max_len_i  (max_len_i),
        .store_ok_o (store_ok),
        .trunc_o    (trunc_flag),
        .long_o     (long_flag)
    );

    rxr_ring_ptr #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable_i),
        .base_i    (ring_base_i),
        .advance_i (state_q == ST_CLOSE),
        .wrap_i    (flags_q[FLG_WRAP]),
        .cur_o     (cur_addr)
    );

    always_comb begin
        unique case (crc_idx_q)
            2'd0:    crc_byte = crc_fin[31:24];
            2'd1:    crc_byte = crc_fin[23:16];
            2'd2:    crc_byte = crc_fin[15:8];
            default: crc_byte = crc_fin[7:0];
        endcase
        wbyte = crc_turn ? crc_byte : rx_data_i;
    end

    always_comb begin
        flags_new            = flags_q;
        flags_new[FLG_EMPTY] = 1'b0;
        if (last_q) begin
            flags_new[FLG_LAST] = 1'b1;
            if (trunc_flag) flags_new[FLG_TRUNC] = 1'b1;
            if (long_flag)  flags_new[FLG_LONG]  = 1'b1;
        end
        wb_word.flags = flags_new;
        wb_word.len   = 16'(bufcnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bufptr_q   <= '0;
            bufcnt_q   <= '0;
            flags_q    <= '0;
            pay_done_q <= 1'b0;
            last_q     <= 1'b0;
            crc_idx_q  <= '0;
            ready_q    <= 1'b0;
        end else if (!enable_i) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_start) begin
                        pay_done_q <= 1'b0;
                        last_q     <= 1'b0;
                        state_q    <= ST_FETCH0;
                    end else if (demand_i && !ready_q) begin
                        state_q <= ST_PROBE0;
                    end
                end
                ST_FETCH0: state_q <= ST_FETCH1;
                ST_FETCH1: begin
                    flags_q <= mem_rdata_i[31:16];
                    if (!mem_rdata_i[16 + FLG_EMPTY]) begin
                        state_q <= pay_done_q ? ST_PROBE0 : ST_DROP;
                    end else begin
                        state_q <= ST_FETCH2;
                    end
                end
                ST_FETCH2: begin
                    bufptr_q <= mem_rdata_i[ADDR_W-1:0];
                    bufcnt_q <= '0;
                    state_q  <= ST_DATA;
                end
                ST_DATA: begin
                    if (byte_take && rx_last_i) begin
                        pay_done_q <= 1'b1;
                        crc_idx_q  <= '0;
                    end
                    if (wr_byte) bufcnt_q <= bufcnt_q + 1'b1;
                    if (crc_turn) crc_idx_q <= crc_idx_q + 1'b1;
                    if (crc_end) begin
                        last_q  <= 1'b1;
                        state_q <= ST_CLOSE;
                    end else if (wr_byte && buf_full) begin
                        last_q  <= 1'b0;
                        state_q <= ST_CLOSE;
                    end
                end
                ST_CLOSE: state_q <= last_q ? ST_PROBE0 : ST_FETCH0;
                ST_DROP: begin
                    if (rx_valid_i && rx_last_i) state_q <= ST_PROBE0;
                end
                ST_PROBE0: state_q <= ST_PROBE1;
                ST_PROBE1: begin
                    ready_q <= mem_rdata_i[16 + FLG_EMPTY];
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_be_o    = 4'b0000;
        mem_wdata_o = '0;
        evt_rxb_o   = 1'b0;
        evt_rxf_o   = 1'b0;
        unique case (state_q)
            ST_FETCH0, ST_PROBE0: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = cur_addr;
            end
            ST_FETCH1: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = cur_addr + ADDR_W'(4);
            end
            ST_DATA: begin
                mem_wr_o    = wr_byte;
                mem_addr_o  = byte_addr;
                mem_be_o    = wr_byte ? lane_be(byte_addr[1:0]) : 4'b0000;
                mem_wdata_o = {4{wbyte}};
            end
            ST_CLOSE: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = cur_addr;
                mem_be_o    = 4'b1111;
                mem_wdata_o = wb_word;
                evt_rxf_o   = last_q;
                evt_rxb_o   = !last_q;
            end
            default: ;
        endcase
    end

    assign rx_ready_o = ((state_q == ST_DATA) && !pay_done_q) || (state_q == ST_DROP);
    assign ready_o    = ready_q;
    assign rdar_o     = {7'b0, ready_q, 24'b0};

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int BUFSZ_W = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               enable_i,
    input logic [BUFSZ_W-1:0] max_buf_i,
    input logic               rx_ready_o,
    input logic               mem_wr_o,
    input logic [3:0]         mem_be_o,
    input logic [31:0]        mem_wdata_o,
    input logic               ready_o,
    input logic               evt_rxb_o,
    input logic               evt_rxf_o
);

    logic [15:0] size_chk;
    always_comb begin
        size_chk = 16'({max_buf_i[BUFSZ_W-1:4], 4'b0000});
        if (size_chk == 16'd0) size_chk = 16'd16;
    end

    assert_empty_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && mem_be_o == 4'b1111) |-> !mem_wdata_o[31]);

    assert_frame_has_last_R5: assert property (@(posedge clk) disable iff (rst)
        evt_rxf_o |-> (mem_wr_o && mem_wdata_o[27]));

    assert_buffer_no_last_R5: assert property (@(posedge clk) disable iff (rst)
        evt_rxb_o |-> (mem_wr_o && !mem_wdata_o[27]));

    assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_rxb_o, evt_rxf_o}));

    assert_partial_full_R4: assert property (@(posedge clk) disable iff (rst)
        evt_rxb_o |-> (mem_wdata_o[15:0] == size_chk));

    assert_len_bound_R4: assert property (@(posedge clk) disable iff (rst)
        evt_rxf_o |-> (mem_wdata_o[15:0] <= size_chk && mem_wdata_o[15:0] != 16'd0));

    assert_trunc_long_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_rxf_o && mem_wdata_o[16]) |-> mem_wdata_o[21]);

    assert_single_lane_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && mem_be_o != 4'b1111) |-> ($countones(mem_be_o) == 1));

    assert_disable_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !ready_o);

    assert_stream_gated_R10: assert property (@(posedge clk) disable iff (rst)
        rx_ready_o |-> ready_o);

endmodule

bind rx_ring_engine rxr_checker #(
    .BUFSZ_W (BUFSZ_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (enable_i),
    .max_buf_i   (max_buf_i),
    .rx_ready_o  (rx_ready_o),
    .mem_wr_o    (mem_wr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .ready_o     (ready_o),
    .evt_rxb_o   (evt_rxb_o),
    .evt_rxf_o   (evt_rxf_o)
);

// File: tb/rx_ring_engine_tb_top.sv
module rx_ring_engine_tb_top;

    localparam int MAXF = 2032;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable_i, demand_i;
    logic [31:0] ring_base_i;
    logic [10:0] max_buf_i;
    logic [15:0] max_len_i;
    logic        rx_valid_i, rx_last_i;
    logic [7:0]  rx_data_i;
    logic        rx_ready_o, mem_rd_o, mem_wr_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  mem_be_o;
    logic        ready_o, evt_rxb_o, evt_rxf_o;
    logic [31:0] rdar_o;

    logic [7:0]  mem [0:4095];
    logic [7:0]  pay [0:2047];
    logic [31:0] rd_pend;
    int          checks = 0;
    int          errors = 0;
    int          n_rxb = 0;
    int          n_rxf = 0;

    always #5 clk = ~clk;

    rx_ring_engine dut_i (
        .clk(clk), .rst(rst), .enable_i(enable_i), .demand_i(demand_i),
        .ring_base_i(ring_base_i), .max_buf_i(max_buf_i), .max_len_i(max_len_i),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_last_i(rx_last_i),
        .rx_ready_o(rx_ready_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .ready_o(ready_o), .rdar_o(rdar_o),
        .evt_rxb_o(evt_rxb_o), .evt_rxf_o(evt_rxf_o)
    );

    function automatic logic [31:0] rd32(input logic [31:0] a);
        logic [11:0] b;
        b = {a[11:2], 2'b00};
        return {mem[b], mem[b + 12'd1], mem[b + 12'd2], mem[b + 12'd3]};
    endfunction

    task automatic wr32(input logic [31:0] a, input logic [31:0] v);
        logic [11:0] b;
        b = {a[11:2], 2'b00};
        mem[b] = v[31:24]; mem[b + 12'd1] = v[23:16];
        mem[b + 12'd2] = v[15:8]; mem[b + 12'd3] = v[7:0];
    endtask

    // Memory model and event counters, all sampled mid-cycle.
    always @(negedge clk) begin
        mem_rdata_i <= rd_pend;
        rd_pend     <= mem_rd_o ? rd32(mem_addr_o) : 32'h0;
        if (mem_wr_o) begin
            for (int i = 0; i < 4; i++) begin
                if (mem_be_o[i]) mem[12'({mem_addr_o[11:2], 2'b00}) + 12'(3 - i)] = mem_wdata_o[8*i +: 8];
            end
        end
        if (evt_rxb_o) n_rxb++;
        if (evt_rxf_o) n_rxf++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_crc(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, pay[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] stream_byte(input int idx, input int ps, input logic [31:0] crc);
        if (idx < ps) return pay[idx];
        return crc[8*(3 - (idx - ps)) +: 8];
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic send_frame(input int n, input int seed);
        bit acc;
        for (int i = 0; i < n; i++) pay[i] = 8'((i * 13 + seed) & 255);
        for (int i = 0; i < n; i++) begin
            rx_valid_i = 1'b1;
            rx_data_i  = pay[i];
            rx_last_i  = (i == n - 1);
            do begin
                @(negedge clk); acc = rx_ready_o;
                @(posedge clk); #1;
            end while (!acc);
        end
        rx_valid_i = 1'b0;
        rx_last_i  = 1'b0;
        step(30);
    endtask

    task automatic demand();
        demand_i = 1'b1; step(1); demand_i = 1'b0; step(6);
    endtask

    task automatic arm_ring(input logic [31:0] ptr0);
        wr32(32'h00, 32'h8000_0000); wr32(32'h04, ptr0);
        wr32(32'h08, 32'h8000_0000); wr32(32'h0C, 32'h200);
        wr32(32'h10, 32'h8000_0000); wr32(32'h14, 32'h300);
        wr32(32'h18, 32'hA000_0000); wr32(32'h1C, 32'h400);
    endtask

    task automatic check_frame(input int first, input int n, input int eff,
                               input bit tr_e, input bit lg_e, input string req);
        int total, stored, ps, pos, rem, el, bad;
        logic [31:0] crc, w, ptr, addr;
        bit endbuf;
        total  = n + 4;
        stored = (total > MAXF) ? MAXF : total;
        ps     = stored - 4;
        crc    = exp_crc(n);
        addr   = 32'(first);
        pos    = 0;
        rem    = stored;
        while (rem > 0) begin
            w      = rd32(addr);
            ptr    = rd32(addr + 32'd4);
            el     = (rem < eff) ? rem : eff;
            endbuf = (rem == el);
            chk(int'(w[15:0]) == el, req, "descriptor length", w[15:0], el);
            chk(!w[31] && (w[27] == endbuf), req, "empty/last flags", w[31:16], {endbuf, 11'h0});
            if (endbuf) chk(w[16] == tr_e && w[21] == lg_e, req, "error flags",
                            {w[21], w[16]}, {lg_e, tr_e});
            bad = 0;
            for (int j = 0; j < el; j++)
                if (mem[12'(ptr + 32'(j))] != stream_byte(pos + j, ps, crc)) bad++;
            chk(bad == 0, req, "buffer bytes mismatched", bad, 0);
            pos  += el;
            rem  -= el;
            addr = w[29] ? 32'h0 : addr + 32'd8;
        end
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rb, rf;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        rd_pend = 0; mem_rdata_i = 0;
        rst = 1'b1; enable_i = 1'b0; demand_i = 1'b0; ring_base_i = 32'h0;
        max_buf_i = 11'h010; max_len_i = 16'h05EE;
        rx_valid_i = 1'b0; rx_data_i = 8'h0; rx_last_i = 1'b0;
        step(4);
        rst = 1'b0;
        step(2);
        // R8: reset state
        chk(!ready_o && rdar_o == 0 && !rx_ready_o, "R8", "reset state", rdar_o, 0);

        arm_ring(32'h100);
        enable_i = 1'b1;
        step(2);
        demand();
        chk(ready_o && rdar_o == 32'h0100_0000, "R8", "demand ready", rdar_o, 32'h0100_0000);

        // R1 R5: single buffer frame
        send_frame(10, 3);
        check_frame(0, 10, 16, 0, 0, "R1 R5");
        chk(n_rxf == 1 && n_rxb == 0, "R5", "events after short frame", {n_rxb, n_rxf}, 1);

        // R4 R6: frame split over three buffers ending on the wrap descriptor
        send_frame(30, 77);
        check_frame(8, 30, 16, 0, 0, "R4 R6");
        chk(n_rxf == 2 && n_rxb == 2, "R4", "events after split frame", {n_rxb, n_rxf}, {32'd2, 32'd2});
        // R6 R8: pointer wrapped to desc0, which is no longer empty
        chk(!ready_o && rdar_o == 0, "R6 R8", "ready after wrap", rdar_o, 0);

        // R10: stream held off while not ready
        rb = n_rxb; rf = n_rxf;
        rx_valid_i = 1'b1; rx_data_i = 8'h5A; rx_last_i = 1'b1;
        step(6);
        chk(!rx_ready_o, "R10", "stream ready while not ready", rx_ready_o, 0);
        rx_valid_i = 1'b0; rx_last_i = 1'b0;
        step(2);
        chk(n_rxb == rb && n_rxf == rf && rd32(32'h0) == 32'h0800_000E, "R10",
            "no activity while stalled", rd32(32'h0), 32'h0800_000E);

        // R3 R4: length limit and size masking (0x01F -> 16)
        arm_ring(32'h100);
        demand();
        chk(ready_o, "R8", "demand re-arms", ready_o, 1);
        max_len_i = 16'd20;
        max_buf_i = 11'h01F;
        send_frame(20, 9);
        check_frame(0, 20, 16, 0, 1, "R3 R4");
        max_len_i = 16'h05EE;

        // R7: busy descriptor mid-frame drops the rest
        wr32(32'h10, 32'h8000_0000);
        wr32(32'h18, 32'h2000_0000);
        rb = n_rxb; rf = n_rxf;
        demand();
        send_frame(30, 41);
        chk(rd32(32'h10) == 32'h0000_0010, "R7", "partial descriptor word", rd32(32'h10), 32'h0000_0010);
        chk(rd32(32'h18) == 32'h2000_0000, "R7", "busy descriptor untouched", rd32(32'h18), 32'h2000_0000);
        chk(n_rxb == rb + 1 && n_rxf == rf, "R7", "events on drop", n_rxf - rf, 0);
        chk(!ready_o, "R7", "ready after drop", ready_o, 0);

        // R9: disable clears ready and returns pointer to ring start
        arm_ring(32'h100);
        demand();
        chk(ready_o, "R9", "ready before disable", ready_o, 1);
        enable_i = 1'b0;
        step(1);
        chk(!ready_o, "R9", "ready after disable", ready_o, 0);
        enable_i = 1'b1;
        step(1);
        demand();
        max_buf_i = 11'h00F;
        send_frame(20, 200);
        check_frame(0, 20, 16, 0, 0, "R9 R4");

        // R2: truncation
        arm_ring(32'h800);
        enable_i = 1'b0; step(1); enable_i = 1'b1; step(1);
        demand();
        max_buf_i = 11'h7F0;
        send_frame(2040, 5);
        check_frame(0, 2040, 2032, 1, 1, "R2");
        chk(n_rxf == 5, "R2", "frame event count", n_rxf, 5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule